// File: doc/BRIEF.md
# Board Stack Power-Up Sequencer

This block brings a stack of boards from cold to operational in a fixed order. It turns on a bank of DC/DC converters one at a time, starting at converter 0. Before the next converter is switched on, the current one must report its output in tolerance and a programmable gap must pass. Once every rail is on, all rails must stay good together for a programmable number of cycles. The block then sends a one-cycle strobe that starts configuration of the routing devices and waits, with a time limit, for the configuration to finish. After that it stays in a monitoring stage, in which the run flag is raised and the rail-good flags and the per-sensor over-temperature flags are watched.

If any check fails at any stage, every converter is switched off at once. A fault code records the stage, the cause and the index of the failing rail or sensor. The code and the shutdown stay latched until an external clear, and the clear is taken only while all converters are off. After a clear the block sits idle until a new start pulse arrives. Sensing of the rails and temperatures happens outside this block. Each external check arrives as a single flag, and each rail flag already means "within ±5 % of nominal".

Top module: `pwr_sequencer`

## Requirements
- R1: Reset behaviour. After reset all converter enables, the configuration strobe, the run flag and the fault outputs are 0. The block stays idle, with everything off, until a start pulse is sampled.
- R2: Converter ramp order. Converters are enabled one at a time, in ascending index, and an enabled converter stays on. Converter k+1 is switched on only after converter k has been sampled good and the gap counter has then counted through the programmed gap value (a gap of 0 gives one idle cycle).
- R3: Ramp timeout. If the converter being ramped is not sampled good within its ramp limit, the block faults with stage 0 (ramp), cause 1 (timeout) and the index of that converter.
- R4: Early rail loss. During ramp, settle and configuration, a rail that has already been confirmed good and is then sampled low causes a fault with cause 0 (rail). The index is the lowest such rail. The stage is 0 for ramp, 1 for settle and 2 for configuration.
- R5: Settle and strobe. With all converters on, every rail must be sampled good for the programmed stability count of consecutive cycles. The configuration strobe is then high for exactly one cycle.
- R6: Configuration outcome. During configuration, an error flag gives stage 2 and cause 2 (configuration error). A done flag moves the block to monitoring. If neither arrives within the configuration limit, the block faults with stage 2 and cause 1 (timeout). In both fault cases the index is 0.
- R7: Run flag. The run flag is high only in the monitoring stage, and it is high with every converter on and no fault.
- R8: Monitoring faults. In monitoring, a rail sampled low gives stage 3, cause 0 and the lowest failing rail index. Otherwise an over-temperature flag gives stage 3, cause 3 and the lowest flagged sensor index. A rail loss takes priority over an over-temperature flag in the same cycle.
- R9: Shutdown. On the same clock edge that the fault flag rises, all converter enables, the run flag and the configuration strobe go to 0.
- R10: Fault latching. While the fault flag is high, the fault code is held and start pulses have no effect. A clear sampled while faulted, with all converters off, returns the block to idle with the fault outputs at 0. A clear outside the fault state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Start pulse for the power-up sequence |
| clear_i | input | 1 | Clears a latched fault |
| gap_cycles_i | input | CW | Idle cycles between a converter reporting good and the next enable |
| ramp_limit_i | input | CW | Cycles allowed for the current converter to report good |
| stable_cycles_i | input | CW | Consecutive all-good cycles required before configuration |
| cfg_limit_i | input | CW | Cycles allowed for configuration to finish |
| rail_good_i | input | N_CONV | Per-converter flag: output within tolerance |
| cfg_done_i | input | 1 | Configuration finished |
| cfg_err_i | input | 1 | Configuration failed |
| over_temp_i | input | N_SENS | Per-sensor over-temperature flag |
| conv_en_o | output | N_CONV | Converter enables |
| cfg_start_o | output | 1 | One-cycle configuration start strobe |
| sys_run_o | output | 1 | High in the monitoring stage |
| fault_o | output | 1 | Latched shutdown |
| fault_stage_o | output | 2 | Stage of the fault: 0 ramp, 1 settle, 2 configuration, 3 monitoring |
| fault_cause_o | output | 2 | Cause: 0 rail, 1 timeout, 2 configuration error, 3 over-temperature |
| fault_index_o | output | IW | Index of the failing rail or sensor |

## Verification
The assertions assume the four programmed limits are at least 1 where a limit ends a count, and that they are held steady while a sequence runs. They also assume that a rail flag can be high only while its converter is enabled. The bench keeps within these assumptions. It loads the limits only while the block is idle or faulted. It produces each rail-good flag from the enable it sees on the port, after a per-rail delay, and it forces a rail low only on a rail that is already on. The configuration responder drives done only after it has seen the strobe, and it drops its state on every shutdown.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RAMP,
    ST_GAP,
    ST_SETTLE,
    ST_CONFIG,
    ST_RUN,
    ST_FAULT
  } seq_state_e;

  localparam logic [1:0] STG_RAMP   = 2'd0;
  localparam logic [1:0] STG_SETTLE = 2'd1;
  localparam logic [1:0] STG_CONFIG = 2'd2;
  localparam logic [1:0] STG_RUN    = 2'd3;

  localparam logic [1:0] CAUSE_RAIL    = 2'd0;
  localparam logic [1:0] CAUSE_TIMEOUT = 2'd1;
  localparam logic [1:0] CAUSE_CFGERR  = 2'd2;
  localparam logic [1:0] CAUSE_THERM   = 2'd3;

endpackage

// File: rtl/pseq_rst_sync.sv
module pseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pseq_lowest_set.sv
module pseq_lowest_set #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pseq_counter.sv
module pseq_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/pwr_sequencer.sv
module pwr_sequencer
  import pseq_pkg::*;
#(
  parameter int N_CONV = 6,
  parameter int N_SENS = 8,
  parameter int CW     = 16,
  parameter int MAXN   = (N_CONV > N_SENS) ? N_CONV : N_SENS,
  parameter int IW     = (MAXN > 1) ? $clog2(MAXN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              clear_i,
  input  logic [CW-1:0]     gap_cycles_i,
  input  logic [CW-1:0]     ramp_limit_i,
  input  logic [CW-1:0]     stable_cycles_i,
  input  logic [CW-1:0]     cfg_limit_i,
  input  logic [N_CONV-1:0] rail_good_i,
  input  logic              cfg_done_i,
  input  logic              cfg_err_i,
  input  logic [N_SENS-1:0] over_temp_i,
  output logic [N_CONV-1:0] conv_en_o,
  output logic              cfg_start_o,
  output logic              sys_run_o,
  output logic              fault_o,
  output logic [1:0]        fault_stage_o,
  output logic [1:0]        fault_cause_o,
  output logic [IW-1:0]     fault_index_o
);

  localparam logic [IW-1:0] LAST_CONV = IW'(N_CONV - 1);

  logic          rst_n_i;
  seq_state_e    st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [CW-1:0] cnt;
  logic          cnt_clr, cnt_inc;

  logic          raise;
  logic [1:0]    raise_stage, raise_cause;
  logic [IW-1:0] raise_idx;
  logic          flt_clr;

  logic [1:0]    f_stage_q, f_cause_q;
  logic [IW-1:0] f_idx_q;

  logic [N_CONV-1:0] chk_mask, en_vec, rail_bad;
  logic              bad_found, hot_found;
  logic [IW-1:0]     bad_idx, hot_idx;
  logic              all_on, ramping;

  logic ramp_hit, stable_hit, cfg_hit, gap_done;

  pseq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  pseq_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n_i),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .count (cnt)
  );

  assign all_on  = (st_q == ST_SETTLE) || (st_q == ST_CONFIG) || (st_q == ST_RUN);
  assign ramping = (st_q == ST_RAMP) || (st_q == ST_GAP);

  // Per-converter enable and which rails are already confirmed
  for (genvar j = 0; j < N_CONV; j++) begin : g_rail
    assign en_vec[j]   = all_on || (ramping && (IW'(j) <= idx_q));
    assign chk_mask[j] = all_on
                       || ((st_q == ST_RAMP) && (IW'(j) <  idx_q))
                       || ((st_q == ST_GAP)  && (IW'(j) <= idx_q));
  end

  assign rail_bad = chk_mask & ~rail_good_i;

  pseq_lowest_set #(.W(N_CONV), .IW(IW)) u_bad (
    .vec   (rail_bad),
    .found (bad_found),
    .idx   (bad_idx)
  );

  pseq_lowest_set #(.W(N_SENS), .IW(IW)) u_hot (
    .vec   (over_temp_i),
    .found (hot_found),
    .idx   (hot_idx)
  );

  assign ramp_hit   = (cnt == ramp_limit_i - CW'(1));
  assign stable_hit = (cnt == stable_cycles_i - CW'(1));
  assign cfg_hit    = (cnt == cfg_limit_i - CW'(1));
  assign gap_done   = (cnt >= gap_cycles_i);

  // Next-state logic
  always_comb begin
    st_d        = st_q;
    idx_d       = idx_q;
    cnt_clr     = 1'b0;
    cnt_inc     = 1'b0;
    raise       = 1'b0;
    raise_stage = STG_RAMP;
    raise_cause = CAUSE_RAIL;
    raise_idx   = '0;
    flt_clr     = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (go_i) begin
          st_d    = ST_RAMP;
          idx_d   = '0;
          cnt_clr = 1'b1;
        end
      end
      ST_RAMP: begin
        if (bad_found) begin
          raise = 1'b1; raise_stage = STG_RAMP;
          raise_cause = CAUSE_RAIL; raise_idx = bad_idx;
        end else if (rail_good_i[idx_q]) begin
          cnt_clr = 1'b1;
          st_d    = (idx_q == LAST_CONV) ? ST_SETTLE : ST_GAP;
        end else if (ramp_hit) begin
          raise = 1'b1; raise_stage = STG_RAMP;
          raise_cause = CAUSE_TIMEOUT; raise_idx = idx_q;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_GAP: begin
        if (bad_found) begin
          raise = 1'b1; raise_stage = STG_RAMP;
          raise_cause = CAUSE_RAIL; raise_idx = bad_idx;
        end else if (gap_done) begin
          st_d    = ST_RAMP;
          idx_d   = idx_q + 1'b1;
          cnt_clr = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (bad_found) begin
          raise = 1'b1; raise_stage = STG_SETTLE;
          raise_cause = CAUSE_RAIL; raise_idx = bad_idx;
        end else if (stable_hit) begin
          st_d    = ST_CONFIG;
          cnt_clr = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_CONFIG: begin
        if (bad_found) begin
          raise = 1'b1; raise_stage = STG_CONFIG;
          raise_cause = CAUSE_RAIL; raise_idx = bad_idx;
        end else if (cfg_err_i) begin
          raise = 1'b1; raise_stage = STG_CONFIG;
          raise_cause = CAUSE_CFGERR;
        end else if (cfg_done_i) begin
          st_d    = ST_RUN;
          cnt_clr = 1'b1;
        end else if (cfg_hit) begin
          raise = 1'b1; raise_stage = STG_CONFIG;
          raise_cause = CAUSE_TIMEOUT;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_RUN: begin
        if (bad_found) begin
          raise = 1'b1; raise_stage = STG_RUN;
          raise_cause = CAUSE_RAIL; raise_idx = bad_idx;
        end else if (hot_found) begin
          raise = 1'b1; raise_stage = STG_RUN;
          raise_cause = CAUSE_THERM; raise_idx = hot_idx;
        end
      end
      ST_FAULT: begin
        if (clear_i && (conv_en_o == '0)) begin
          st_d    = ST_IDLE;
          flt_clr = 1'b1;
        end
      end
      default: st_d = ST_FAULT;
    endcase

    if (raise) begin
      st_d    = ST_FAULT;
      cnt_clr = 1'b1;
      cnt_inc = 1'b0;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  // Fault code register, loaded on a raise, zeroed on an accepted clear
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      f_stage_q <= '0;
      f_cause_q <= '0;
      f_idx_q   <= '0;
    end else if (raise) begin
      f_stage_q <= raise_stage;
      f_cause_q <= raise_cause;
      f_idx_q   <= raise_idx;
    end else if (flt_clr) begin
      f_stage_q <= '0;
      f_cause_q <= '0;
      f_idx_q   <= '0;
    end
  end

  assign conv_en_o     = en_vec;
  assign cfg_start_o   = (st_q == ST_CONFIG) && (cnt == '0);
  assign sys_run_o     = (st_q == ST_RUN);
  assign fault_o       = (st_q == ST_FAULT);
  assign fault_stage_o = f_stage_q;
  assign fault_cause_o = f_cause_q;
  assign fault_index_o = f_idx_q;

endmodule

// File: rtl/pwr_sequencer_chk.sv
module pwr_sequencer_chk #(
  parameter int N_CONV = 6,
  parameter int N_SENS = 8,
  parameter int IW     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear_i,
  input logic [N_CONV-1:0] rail_good_i,
  input logic [N_CONV-1:0] conv_en_o,
  input logic              cfg_start_o,
  input logic              sys_run_o,
  input logic              fault_o,
  input logic [1:0]        fault_stage_o,
  input logic [1:0]        fault_cause_o,
  input logic [IW-1:0]     fault_index_o
);

  // R2: a change in the enables (other than switching all off) adds exactly one converter
  a_r2_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_en_o != '0 && !$stable(conv_en_o))
      |-> $countones(conv_en_o) == $countones($past(conv_en_o)) + 1);

  // R2: converters already on were all good in the cycle before another is added
  a_r2_prior_good: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(conv_en_o) > $countones($past(conv_en_o)) && $past(conv_en_o) != '0)
      |-> (($past(rail_good_i) & $past(conv_en_o)) == $past(conv_en_o)));

  // R5: the configuration strobe lasts one cycle
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_start_o |=> !cfg_start_o);

  // R7: running means every converter is on and there is no fault
  a_r7_run_full: assert property (@(posedge clk) disable iff (!rst_n)
    sys_run_o |-> (conv_en_o == {N_CONV{1'b1}}) && !fault_o);

  // R8: a rail lost while running shuts down with a rail cause
  a_r8_run_rail_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_run_o && rail_good_i != {N_CONV{1'b1}})
      |=> fault_o && fault_cause_o == 2'd0 && fault_stage_o == 2'd3);

  // R9: shutdown removes every enable and the strobe
  a_r9_fault_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (conv_en_o == '0) && !sys_run_o && !cfg_start_o);

  // R10: fault code held until a clear
  a_r10_fault_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fault_o) && !$past(clear_i))
      |-> fault_o && $stable(fault_stage_o) && $stable(fault_cause_o)
          && $stable(fault_index_o));

  // R10: a clear taken while faulted leaves the fault state
  a_r10_clear_taken: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fault_o) && $past(clear_i)) |-> !fault_o);

endmodule

bind pwr_sequencer pwr_sequencer_chk #(
  .N_CONV (N_CONV),
  .N_SENS (N_SENS),
  .IW     (IW)
) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .clear_i       (clear_i),
  .rail_good_i   (rail_good_i),
  .conv_en_o     (conv_en_o),
  .cfg_start_o   (cfg_start_o),
  .sys_run_o     (sys_run_o),
  .fault_o       (fault_o),
  .fault_stage_o (fault_stage_o),
  .fault_cause_o (fault_cause_o),
  .fault_index_o (fault_index_o)
);

// File: tb/test_pwr_sequencer.sv
module test_pwr_sequencer;
  localparam int N_CONV = 6;
  localparam int N_SENS = 8;
  localparam int CW     = 16;
  localparam int IW     = 3;

  // model state codes
  localparam int M_IDLE = 0, M_RAMP = 1, M_GAP = 2, M_SETTLE = 3,
                 M_CONFIG = 4, M_RUN = 5, M_FAULT = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic              go_i, clear_i;
  logic [CW-1:0]     gap_cycles_i, ramp_limit_i, stable_cycles_i, cfg_limit_i;
  logic [N_CONV-1:0] rail_good_i;
  logic              cfg_done_i, cfg_err_i;
  logic [N_SENS-1:0] over_temp_i;
  logic [N_CONV-1:0] conv_en_o;
  logic              cfg_start_o, sys_run_o, fault_o;
  logic [1:0]        fault_stage_o, fault_cause_o;
  logic [IW-1:0]     fault_index_o;

  pwr_sequencer #(.N_CONV(N_CONV), .N_SENS(N_SENS), .CW(CW)) i_pwr_sequencer (
    .clk(clk), .rst_n(rst_n), .go_i(go_i), .clear_i(clear_i),
    .gap_cycles_i(gap_cycles_i), .ramp_limit_i(ramp_limit_i),
    .stable_cycles_i(stable_cycles_i), .cfg_limit_i(cfg_limit_i),
    .rail_good_i(rail_good_i), .cfg_done_i(cfg_done_i), .cfg_err_i(cfg_err_i),
    .over_temp_i(over_temp_i), .conv_en_o(conv_en_o), .cfg_start_o(cfg_start_o),
    .sys_run_o(sys_run_o), .fault_o(fault_o), .fault_stage_o(fault_stage_o),
    .fault_cause_o(fault_cause_o), .fault_index_o(fault_index_o)
  );

  int checks = 0;
  int failures = 0;
  bit cmp_on = 1'b0;

  // reference model
  int m_st, m_k, m_cnt, m_stage, m_cause, m_idx;

  // stimulus helpers
  int delay   [N_CONV];
  int ontime  [N_CONV];
  bit force_low [N_CONV];
  int cfg_delay = 5;
  bit cfg_auto  = 1'b1;
  int cfg_wait  = -1;

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int low_rail(int upto);
    for (int j = 0; j < upto; j++) if (!rail_good_i[j]) return j;
    return -1;
  endfunction

  function automatic int low_hot();
    for (int j = 0; j < N_SENS; j++) if (over_temp_i[j]) return j;
    return -1;
  endfunction

  task automatic m_raise(int stg, int cause, int idx);
    m_st = M_FAULT; m_stage = stg; m_cause = cause; m_idx = idx; m_cnt = 0;
  endtask

  task automatic model_step();
    int b;
    case (m_st)
      M_IDLE: if (go_i) begin m_st = M_RAMP; m_k = 0; m_cnt = 0; end
      M_RAMP: begin
        b = low_rail(m_k);
        if (b >= 0) m_raise(0, 0, b);
        else if (rail_good_i[m_k]) begin
          m_st = (m_k == N_CONV - 1) ? M_SETTLE : M_GAP; m_cnt = 0;
        end else if (m_cnt == int'(ramp_limit_i) - 1) m_raise(0, 1, m_k);
        else m_cnt++;
      end
      M_GAP: begin
        b = low_rail(m_k + 1);
        if (b >= 0) m_raise(0, 0, b);
        else if (m_cnt >= int'(gap_cycles_i)) begin m_st = M_RAMP; m_k++; m_cnt = 0; end
        else m_cnt++;
      end
      M_SETTLE: begin
        b = low_rail(N_CONV);
        if (b >= 0) m_raise(1, 0, b);
        else if (m_cnt == int'(stable_cycles_i) - 1) begin m_st = M_CONFIG; m_cnt = 0; end
        else m_cnt++;
      end
      M_CONFIG: begin
        b = low_rail(N_CONV);
        if (b >= 0) m_raise(2, 0, b);
        else if (cfg_err_i) m_raise(2, 2, 0);
        else if (cfg_done_i) begin m_st = M_RUN; m_cnt = 0; end
        else if (m_cnt == int'(cfg_limit_i) - 1) m_raise(2, 1, 0);
        else m_cnt++;
      end
      M_RUN: begin
        b = low_rail(N_CONV);
        if (b >= 0) m_raise(3, 0, b);
        else if (low_hot() >= 0) m_raise(3, 3, low_hot());
      end
      M_FAULT: if (clear_i) begin m_st = M_IDLE; m_stage = 0; m_cause = 0; m_idx = 0; end
      default: ;
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = M_IDLE; m_k = 0; m_cnt = 0; m_stage = 0; m_cause = 0; m_idx = 0;
    end else begin
      model_step();
    end
  end

  function automatic int exp_en();
    int v = 0;
    if (m_st == M_RAMP || m_st == M_GAP) v = (1 << (m_k + 1)) - 1;
    else if (m_st == M_SETTLE || m_st == M_CONFIG || m_st == M_RUN) v = (1 << N_CONV) - 1;
    return v;
  endfunction

  function automatic string tag_of();
    case (m_st)
      M_IDLE:   return "R1";
      M_RAMP, M_GAP: return "R2";
      M_SETTLE: return "R5";
      M_CONFIG: return "R6";
      M_RUN:    return "R7";
      default:  return "R9";
    endcase
  endfunction

  // per-cycle comparison against the model, then rail and configuration responders
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      check(tag_of(), int'(conv_en_o), exp_en(), "conv_en_o");
      check(tag_of(), int'(cfg_start_o), int'(m_st == M_CONFIG && m_cnt == 0), "cfg_start_o");
      check(tag_of(), int'(sys_run_o), int'(m_st == M_RUN), "sys_run_o");
      check(tag_of(), int'(fault_o), int'(m_st == M_FAULT), "fault_o");
      check("R10", int'(fault_stage_o), m_stage, "fault_stage_o");
      check("R10", int'(fault_cause_o), m_cause, "fault_cause_o");
      check("R10", int'(fault_index_o), m_idx, "fault_index_o");
    end
    for (int j = 0; j < N_CONV; j++) begin
      if (conv_en_o[j]) ontime[j]++; else ontime[j] = 0;
      rail_good_i[j] = conv_en_o[j] && (ontime[j] >= delay[j]) && !force_low[j];
    end
    if (fault_o || conv_en_o == '0) cfg_wait = -1;
    else if (cfg_start_o) cfg_wait = 0;
    else if (cfg_wait >= 0) cfg_wait++;
    cfg_done_i = cfg_auto && (cfg_wait >= cfg_delay);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_go();
    @(negedge clk); go_i = 1'b1;
    @(negedge clk); go_i = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); clear_i = 1'b1;
    @(negedge clk); clear_i = 1'b0;
  endtask

  task automatic run_to(int target, int maxc, string req);
    int n = 0;
    while (m_st != target && n < maxc) begin @(negedge clk); n++; end
    check(req, m_st, target, "reached stage");
  endtask

  task automatic chk_fault(string req, int stg, int cause, int idx);
    check(req, int'(fault_o), 1, "fault_o");
    check(req, int'(fault_stage_o), stg, "fault_stage_o");
    check(req, int'(fault_cause_o), cause, "fault_cause_o");
    check(req, int'(fault_index_o), idx, "fault_index_o");
    check("R9", int'(conv_en_o), 0, "conv_en_o after shutdown");
  endtask

  task automatic recover();
    for (int j = 0; j < N_CONV; j++) begin force_low[j] = 1'b0; delay[j] = 2; end
    over_temp_i = '0; cfg_err_i = 1'b0; cfg_auto = 1'b1;
    pulse_clear();
    cyc(2);
    check("R10", int'(fault_o), 0, "fault_o after clear");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; go_i = 1'b0; clear_i = 1'b0;
    gap_cycles_i = 16'd3; ramp_limit_i = 16'd10;
    stable_cycles_i = 16'd4; cfg_limit_i = 16'd20;
    cfg_err_i = 1'b0; cfg_done_i = 1'b0; over_temp_i = '0; rail_good_i = '0;
    for (int j = 0; j < N_CONV; j++) begin delay[j] = 2; ontime[j] = 0; force_low[j] = 1'b0; end
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
    cmp_on = 1'b1;

    // R1: reset state and idle without a start pulse
    check("R1", int'(conv_en_o), 0, "conv_en_o after reset");
    check("R1", int'(fault_o), 0, "fault_o after reset");
    check("R1", int'(sys_run_o), 0, "sys_run_o after reset");
    cyc(3);
    check("R1", int'(conv_en_o), 0, "conv_en_o idle");

    // R2 R5 R7: full power-up
    pulse_go();
    run_to(M_CONFIG, 400, "R5");
    check("R5", int'(cfg_start_o), 1, "strobe on entry");
    cyc(1);
    check("R5", int'(cfg_start_o), 0, "strobe one cycle");
    run_to(M_RUN, 100, "R6");
    check("R7", int'(sys_run_o), 1, "sys_run_o in monitoring");
    check("R7", int'(conv_en_o), (1 << N_CONV) - 1, "all converters on");
    // R10: clear outside a fault has no effect
    pulse_clear();
    cyc(2);
    check("R10", int'(sys_run_o), 1, "run after stray clear");
    check("R10", int'(fault_o), 0, "no fault after stray clear");
    // R8: two hot sensors, lowest index reported
    @(negedge clk); over_temp_i = 8'b0100_0100;
    cyc(2);
    chk_fault("R8", 3, 3, 2);
    // R10: start ignored while faulted
    pulse_go();
    cyc(2);
    chk_fault("R10", 3, 3, 2);
    recover();

    // R3: converter 2 never comes good
    delay[2] = 100000;
    pulse_go();
    run_to(M_FAULT, 400, "R3");
    cyc(1);
    chk_fault("R3", 0, 1, 2);
    recover();

    // R4: rail 0 drops while ramping later converters
    pulse_go();
    while (!(m_st == M_GAP && m_k == 1)) @(negedge clk);
    force_low[0] = 1'b1;
    cyc(3);
    chk_fault("R4", 0, 0, 0);
    recover();

    // R4: rail 3 drops during settle
    stable_cycles_i = 16'd30;
    pulse_go();
    run_to(M_SETTLE, 400, "R4");
    force_low[3] = 1'b1;
    cyc(3);
    chk_fault("R4", 1, 0, 3);
    recover();
    stable_cycles_i = 16'd4;

    // R6: configuration error
    cfg_auto = 1'b0;
    pulse_go();
    run_to(M_CONFIG, 400, "R6");
    cyc(2);
    cfg_err_i = 1'b1;
    cyc(2);
    chk_fault("R6", 2, 2, 0);
    recover();

    // R6: configuration timeout
    cfg_auto = 1'b0; cfg_limit_i = 16'd8;
    pulse_go();
    run_to(M_FAULT, 400, "R6");
    cyc(1);
    chk_fault("R6", 2, 1, 0);
    recover();
    cfg_limit_i = 16'd20;

    // R8: rail loss and over-temperature together, rail wins
    pulse_go();
    run_to(M_RUN, 400, "R8");
    cyc(2);
    force_low[4] = 1'b1; over_temp_i = 8'b0000_0001;
    cyc(3);
    chk_fault("R8", 3, 0, 4);
    recover();

    // R2: boundary limits, zero gap and one-cycle stability
    gap_cycles_i = 16'd0; stable_cycles_i = 16'd1;
    for (int j = 0; j < N_CONV; j++) delay[j] = 1;
    pulse_go();
    run_to(M_RUN, 400, "R2");
    check("R2", int'(conv_en_o), (1 << N_CONV) - 1, "all on after fast ramp");

    cyc(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule